// File: doc/BRIEF.md
# Operand-Select Four-Function ALU

This block is the arithmetic and logic core of a simple integer datapath. It takes a first operand and picks its second operand from one of two 32-bit sources: a register value or a sign-extended immediate. A 3-bit control word then chooses one of four functions: bitwise AND, bitwise OR, add or subtract, and signed set-less-than.

The result is purely combinational. It settles in the same cycle that the operands and control change, and it carries no latency. The clock and reset pins are on the interface so that the block fits a clocked datapath and can be observed by clocked checks. Neither pin drives the result path. No flags are produced, and add and subtract wrap silently.

Top module: `alu_opsel`

## Requirements
- R1: `b_sel_i` = 0 makes `reg_b_i` the second operand, and `b_sel_i` = 1 makes `imm_b_i` the second operand. `op_a_i` is always the first operand.
- R2: `ctrl_i[1:0]` = 2'b00 gives the bitwise AND of the two operands.
- R3: `ctrl_i[1:0]` = 2'b01 gives the bitwise OR of the two operands.
- R4: `ctrl_i` = 3'b010 gives the first operand plus the second, modulo 2^32.
- R5: `ctrl_i` = 3'b110 gives the first operand minus the second, modulo 2^32.
- R6: `ctrl_i[1:0]` = 2'b11 gives 32'd1 when the first operand is less than the second as two's-complement signed values, and 32'd0 otherwise. Bits 31..1 of the result are always zero in this mode, including when the subtraction overflows.
- R7: `ctrl_i[2]` has no effect on the result when `ctrl_i[1:0]` is 2'b00, 2'b01 or 2'b11.
- R8: `result_o` follows the current inputs with no clock latency. Neither a clock edge nor the state of `rst_ni` changes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Datapath clock; not used by the result path |
| rst_ni | input | 1 | Active-low asynchronous reset; not used by the result path |
| op_a_i | input | 32 | First operand |
| reg_b_i | input | 32 | Register candidate for the second operand |
| imm_b_i | input | 32 | Sign-extended immediate candidate for the second operand |
| b_sel_i | input | 1 | Second operand select: 0 register, 1 immediate |
| ctrl_i | input | 3 | Bit 2: subtract; bits 1..0: function (00 AND, 01 OR, 10 add/sub, 11 SLT) |
| result_o | output | 32 | Function result |

## Verification
Subtraction and set-less-than both use the single adder in the same cycle. Set-less-than forces the adder into subtract mode whatever bit 2 holds, so a fault in how the two share it would show up as a wrong comparison or a wrong difference. The bench provokes this by issuing SLT with bit 2 both clear and set, on operand pairs whose raw difference overflows (most negative against positive, most positive against minus one). These are mixed with back-to-back ADD, SUB and SLT operations on random operands. Each result is judged against a reference in the bench that compares the operands signed, without using the sign of the difference, so a wrong sign or overflow decision cannot cancel itself out.

// File: rtl/alu_opsel_pkg.sv
package alu_opsel_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CTRL_W = 3;

  typedef enum logic [1:0] {
    FN_AND   = 2'b00,
    FN_OR    = 2'b01,
    FN_ARITH = 2'b10,
    FN_SLT   = 2'b11
  } alu_fn_e;
endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] reg_b_i,
  input  logic [W-1:0] imm_b_i,
  input  logic         sel_i,
  output logic [W-1:0] b_o
);
  always_comb begin
    b_o = sel_i ? imm_b_i : reg_b_i;
  end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         or_sel_i,
  output logic [W-1:0] y_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      y_o[i] = or_sel_i ? (a_i[i] | b_i[i]) : (a_i[i] & b_i[i]);
    end
  end
endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         lt_o
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] b_x;
  logic [W:0]   full;
  logic         ovf;

  always_comb begin
    b_x   = b_i ^ {W{sub_i}};
    full  = {1'b0, a_i} + {1'b0, b_x} + {{W{1'b0}}, sub_i};
    sum_o = full[W-1:0];
    // signed overflow: operand signs agree, result sign differs
    ovf   = (a_i[MSB] == b_x[MSB]) && (sum_o[MSB] != a_i[MSB]);
    lt_o  = sum_o[MSB] ^ ovf;
  end
endmodule

// File: rtl/alu_opsel.sv
module alu_opsel
  import alu_opsel_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      op_a_i,
  input  logic [W-1:0]      reg_b_i,
  input  logic [W-1:0]      imm_b_i,
  input  logic              b_sel_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [W-1:0]      result_o
);
  alu_fn_e      fn;
  logic         sub_en;
  logic [W-1:0] op_b;
  logic [W-1:0] logic_y;
  logic [W-1:0] arith_y;
  logic         lt;

  // clock and reset are interface-only; the result path is combinational
  logic unused_clk_rst;
  assign unused_clk_rst = clk_i ^ rst_ni;

  assign fn     = alu_fn_e'(ctrl_i[1:0]);
  // SLT needs a - b regardless of bit 2
  assign sub_en = ctrl_i[2] | (fn == FN_SLT);

  alu_operand_sel #(.W(W)) u_opsel (
    .reg_b_i (reg_b_i),
    .imm_b_i (imm_b_i),
    .sel_i   (b_sel_i),
    .b_o     (op_b)
  );

  alu_logic_unit #(.W(W)) u_logic (
    .a_i      (op_a_i),
    .b_i      (op_b),
    .or_sel_i (fn == FN_OR),
    .y_o      (logic_y)
  );

  alu_arith_unit #(.W(W)) u_arith (
    .a_i   (op_a_i),
    .b_i   (op_b),
    .sub_i (sub_en),
    .sum_o (arith_y),
    .lt_o  (lt)
  );

  always_comb begin
    unique case (fn)
      FN_AND, FN_OR: result_o = logic_y;
      FN_ARITH:      result_o = arith_y;
      FN_SLT:        result_o = {{(W-1){1'b0}}, lt};
      default:       result_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_opsel_chk.sv
module alu_opsel_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] op_a_i,
  input logic [W-1:0] reg_b_i,
  input logic [W-1:0] imm_b_i,
  input logic         b_sel_i,
  input logic [2:0]   ctrl_i,
  input logic [W-1:0] result_o
);
  logic [W-1:0] b_eff;
  assign b_eff = b_sel_i ? imm_b_i : reg_b_i;

  // OR with a zero first operand passes the chosen operand through
  assert_sel_reg_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[1:0] == 2'b01 && op_a_i == '0 && !b_sel_i) |-> result_o == reg_b_i);
  assert_sel_imm_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[1:0] == 2'b01 && op_a_i == '0 && b_sel_i) |-> result_o == imm_b_i);

  assert_and_subset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[1:0] == 2'b00) |-> ((result_o & ~op_a_i) == '0 && (result_o & ~b_eff) == '0));

  assert_or_cover_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[1:0] == 2'b01) |-> ((result_o & op_a_i) == op_a_i && (result_o & b_eff) == b_eff));

  assert_add_inverse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i == 3'b010) |-> (W'(result_o - b_eff) == op_a_i));

  assert_sub_inverse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i == 3'b110) |-> (W'(result_o + b_eff) == op_a_i));

  assert_slt_upper_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[1:0] == 2'b11) |-> (result_o[W-1:1] == '0));
  assert_slt_sign_split_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[1:0] == 2'b11 && op_a_i[W-1] != b_eff[W-1]) |-> (result_o[0] == op_a_i[W-1]));

  assert_slt_equal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[1:0] == 2'b11 && op_a_i == b_eff) |-> (result_o == '0));
endmodule

bind alu_opsel alu_opsel_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .op_a_i   (op_a_i),
  .reg_b_i  (reg_b_i),
  .imm_b_i  (imm_b_i),
  .b_sel_i  (b_sel_i),
  .ctrl_i   (ctrl_i),
  .result_o (result_o)
);

// File: tb/alu_opsel_tb.sv
`timescale 1ns/1ps
module alu_opsel_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] op_a_i = '0;
  logic [31:0] reg_b_i = '0;
  logic [31:0] imm_b_i = '0;
  logic        b_sel_i = 1'b0;
  logic [2:0]  ctrl_i = '0;
  logic [31:0] result_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  alu_opsel u_dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_a_i   (op_a_i),
    .reg_b_i  (reg_b_i),
    .imm_b_i  (imm_b_i),
    .b_sel_i  (b_sel_i),
    .ctrl_i   (ctrl_i),
    .result_o (result_o)
  );

  function automatic logic [31:0] ref_res(logic [31:0] a, logic [31:0] rb,
                                          logic [31:0] ib, logic sel, logic [2:0] c);
    logic [31:0] b;
    logic lt;
    b = sel ? ib : rb;
    // signed compare built from the signs, not from a difference
    if (a[31] != b[31]) lt = a[31];
    else                lt = (a[30:0] < b[30:0]);
    case (c[1:0])
      2'b00:   return a & b;
      2'b01:   return a | b;
      2'b10:   return c[2] ? a - b : a + b;
      default: return {31'b0, lt};
    endcase
  endfunction

  function automatic string req_of(logic [2:0] c);
    case (c[1:0])
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return c[2] ? "R5" : "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] a, logic [31:0] rb, logic [31:0] ib,
                       logic sel, logic [2:0] c, string req);
    @(negedge clk_i);
    op_a_i = a; reg_b_i = rb; imm_b_i = ib; b_sel_i = sel; ctrl_i = c;
    #1;
    chk(req, result_o, ref_res(a, rb, ib, sel, c));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd7031);
    // R8: reset held, result still follows inputs
    #1;
    chk("R8", result_o, 32'h0);
    op_a_i = 32'h0000_00f0; reg_b_i = 32'h0000_0f0f; ctrl_i = 3'b001;
    #1;
    chk("R8", result_o, 32'h0000_0fff);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: operand source select
    apply(32'h0, 32'h1234_5678, 32'hffff_fff0, 1'b0, 3'b001, "R1");
    apply(32'h0, 32'h1234_5678, 32'hffff_fff0, 1'b1, 3'b001, "R1");
    apply(32'hffff_ffff, 32'haaaa_5555, 32'h0000_ffff, 1'b1, 3'b000, "R1");
    // R2, R3 basic
    apply(32'hf0f0_f0f0, 32'hff00_ff00, 32'h0, 1'b0, 3'b000, "R2");
    apply(32'hf0f0_f0f0, 32'hff00_ff00, 32'h0, 1'b0, 3'b001, "R3");
    // R4 wrap
    apply(32'hffff_ffff, 32'h0000_0001, 32'h0, 1'b0, 3'b010, "R4");
    apply(32'h7fff_ffff, 32'h0, 32'h0000_0001, 1'b1, 3'b010, "R4");
    // R5 wrap
    apply(32'h0, 32'h0000_0001, 32'h0, 1'b0, 3'b110, "R5");
    apply(32'h8000_0000, 32'h0, 32'h0000_0001, 1'b1, 3'b110, "R5");
    // R6 overflow-prone compares
    apply(32'h8000_0000, 32'h0000_0001, 32'h0, 1'b0, 3'b011, "R6");
    apply(32'h7fff_ffff, 32'hffff_ffff, 32'h0, 1'b0, 3'b011, "R6");
    apply(32'hffff_ffff, 32'h0000_0000, 32'h0, 1'b0, 3'b111, "R6");
    apply(32'h0000_0005, 32'h0000_0005, 32'h0, 1'b0, 3'b011, "R6");
    apply(32'h0000_0003, 32'h0, 32'hffff_fffd, 1'b1, 3'b111, "R6");
    // R7: bit 2 ignored outside arithmetic
    apply(32'h8000_0000, 32'h0000_0001, 32'h0, 1'b0, 3'b111, "R7");
    apply(32'h7fff_ffff, 32'h8000_0000, 32'h0, 1'b0, 3'b111, "R7");
    apply(32'hc3c3_c3c3, 32'h0ff0_0ff0, 32'h0, 1'b0, 3'b100, "R7");
    apply(32'hc3c3_c3c3, 32'h0ff0_0ff0, 32'h0, 1'b0, 3'b101, "R7");

    // R8: mid-cycle change with no clock edge between
    @(posedge clk_i);
    #0.5;
    op_a_i = 32'd10; reg_b_i = 32'd3; b_sel_i = 1'b0; ctrl_i = 3'b110;
    #0.5;
    chk("R8", result_o, 32'd7);
    ctrl_i = 3'b010;
    #0.5;
    chk("R8", result_o, 32'd13);
    rst_ni = 1'b0;
    #0.5;
    chk("R8", result_o, 32'd13);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // random mix, with SUB/SLT/ADD bursts
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, rb, ib;
      logic sel;
      logic [2:0] c;
      a  = $urandom;
      rb = $urandom;
      ib = {{16{rb[15]}}, rb[15:0]} ^ 32'($urandom & 32'h0000_00ff);
      if (i % 7 == 0) a = {~rb[31], a[30:0]};
      sel = 1'($urandom);
      c   = 3'($urandom);
      apply(a, rb, ib, sel, c, (c[1:0] == 2'b11 && !c[2]) ? "R7" : req_of(c));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule